// File: doc/BRIEF.md
# System Tick Countdown Timer

This block is a periodic down-counter with a 24-bit count, controlled through four 32-bit registers on a plain strobe port. Software loads a period into the reload register. It chooses which tick enable drives the count: the processor-clock enable or an external reference-tick enable. It then turns the timer on. Each selected tick lowers the count by one. A tick that arrives while the count is already zero is an expiry. An expiry sets a sticky flag, can emit a one-cycle interrupt request pulse, and reloads the count.

Reading the control/status register also clears the flag. A reload value of zero turns the timer into a one-shot: the first expiry switches the enable off. Any write to the current-value register restarts the period. A fixed calibration word can be read so that software can scale its periods.

Reads return data combinationally in the cycle that `rd_en` is high. All state changes happen on the rising clock edge.

Top module: `tick_timer_top`

## Requirements
- R1: After a synchronous active-low reset, all of the following read as zero and `irq_pulse` is low: control/status (offset 0x10), reload (0x14) and current value (0x18).
- R2: Control/status layout: bit 0 is enable, bit 1 is interrupt enable, bit 2 is clock select, and bit 16 is the expiry flag. All other bits read 0. A write changes only bits 2:0, and it can neither set nor clear bit 16.
- R3: While enabled, the count decreases by one on each cycle where the selected tick enable is high. Clock select 1 picks `cpu_tick_en` and clock select 0 picks `ref_tick_en`. The unselected enable has no effect.
- R4: A selected tick while the count is 0 is an expiry. It sets the flag and loads the reload value, so one period is reload+1 selected ticks.
- R5: On an expiry with interrupt enable set, `irq_pulse` is high for exactly the one cycle after the expiring edge. With interrupt enable clear it stays low.
- R6: Reading control/status returns its contents and then clears the flag. If an expiry happens in the same cycle as the read, the flag stays set.
- R7: If the reload value is 0 at an expiry, the enable bit clears by itself and counting stops.
- R8: A write of any data to the current-value register loads the reload value into the count and clears the flag. It takes priority over a tick in the same cycle, which then neither decrements nor expires.
- R9: The current value reads 0 while disabled. Clearing enable freezes the count, and setting it again resumes from the frozen value. If the frozen value is 0, setting enable loads the reload value instead.
- R10: A control write that keeps enable at 1 and changes clock select while the timer is enabled reloads the count.
- R11: The reload register stores 24 bits. Its bits 31:24 and those of the current value read as 0.
- R12: The calibration register (0x1C) always reads 10000 and ignores writes. Any unmapped offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_tick_en | input | 1 | Processor-clock count enable |
| ref_tick_en | input | 1 | External reference-tick count enable |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (its only effect is the flag clear) |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq_pulse | output | 1 | One-cycle interrupt request on expiry |

## Verification
The key collision is an expiry landing in the same cycle as a read of control/status. One clears the flag and the other sets it. The bench provokes this by reading control/status on every cycle while a short period runs on a tick enable held high. It also does this under random strobes and random ticks. A bench model decides that the read returns the old contents and the flag survives. A second collision, a current-value write on an expiring tick, is judged the same way: the restart wins and no interrupt pulse appears.

// File: rtl/tick_pkg.sv
// Shared constants of the tick timer: register offsets and control bit
// positions. Assumes byte offsets fit in 8 bits.
package tick_pkg;
    localparam logic [7:0] OFF_CTRL  = 8'h10;
    localparam logic [7:0] OFF_RELD  = 8'h14;
    localparam logic [7:0] OFF_CURR  = 8'h18;
    localparam logic [7:0] OFF_CALIB = 8'h1C;

    localparam int BIT_EN   = 0;
    localparam int BIT_IE   = 1;
    localparam int BIT_SRC  = 2;
    localparam int BIT_FLAG = 16;
endpackage

// File: rtl/tick_src_sel.sv
// Picks the count enable from the processor-clock or the reference-tick
// enable and gates it with the timer enable. Purely combinational.
module tick_src_sel (
    input  logic en,
    input  logic src_sel,
    input  logic cpu_tick,
    input  logic ref_tick,
    output logic tick
);
    // choose source, then gate by enable
    always_comb begin
        tick = en & (src_sel ? cpu_tick : ref_tick);
    end
endmodule

// File: rtl/tick_down_counter.sv
// Down-counter of CNT_W bits. A load has priority over a tick. A tick at
// zero is reported as an expiry and reloads the counter. Assumes load_val
// is stable for the cycle in which load or expiry occurs.
module tick_down_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // expiry: selected tick on a zero count with no restart pending
    always_comb begin
        expire = tick & ~load & (cnt == '0);
    end

    // count register update
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (load|expire)  cnt <= load_val;
        else if (tick)         cnt <= cnt - ONE;
    end

    // R8
    load_takes_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt == $past(load_val));
    // R3
    dec_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && cnt != '0) |=> cnt == $past(cnt) - ONE);
    // R9
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(cnt));
endmodule

// File: rtl/tick_ctrl_regs.sv
// Register file of the tick timer: decodes writes and reads, keeps the
// control bits, expiry flag and reload value, produces restart requests
// and the interrupt pulse. Assumes single-cycle strobes; reads are
// combinational and their only side effect is the flag clear.
module tick_ctrl_regs
    import tick_pkg::*;
#(
    parameter int          CNT_W  = 24,
    parameter int          ADDR_W = 8,
    parameter int          DATA_W = 32,
    parameter logic [31:0] CALIB  = 32'd10000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              expire,
    output logic              en,
    output logic              src_sel,
    output logic              load,
    output logic [CNT_W-1:0]  reload,
    output logic [DATA_W-1:0] rdata,
    output logic              irq_pulse
);
    logic ie, flag;
    logic wr_ctrl, wr_reld, wr_curr, rd_ctrl;
    logic start_zero, src_change;

    // address decode of strobes
    always_comb begin
        wr_ctrl = wr_en & (addr == ADDR_W'(OFF_CTRL));
        wr_reld = wr_en & (addr == ADDR_W'(OFF_RELD));
        wr_curr = wr_en & (addr == ADDR_W'(OFF_CURR));
        rd_ctrl = rd_en & (addr == ADDR_W'(OFF_CTRL));
    end

    // restart requests: current write, enable from a zero count, source change
    always_comb begin
        start_zero = wr_ctrl & ~en & wdata[BIT_EN] & (cnt == '0);
        src_change = wr_ctrl & en & wdata[BIT_EN] & (wdata[BIT_SRC] != src_sel);
        load       = wr_curr | start_zero | src_change;
    end

    // control bits; a one-shot expiry overrides the written enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en <= 1'b0; ie <= 1'b0; src_sel <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                en      <= wdata[BIT_EN];
                ie      <= wdata[BIT_IE];
                src_sel <= wdata[BIT_SRC];
            end
            if (expire && reload == '0) en <= 1'b0;
        end
    end

    // reload value register
    always_ff @(posedge clk) begin
        if (!rst_n)       reload <= '0;
        else if (wr_reld) reload <= wdata[CNT_W-1:0];
    end

    // sticky expiry flag: set wins over read clear
    always_ff @(posedge clk) begin
        if (!rst_n)                  flag <= 1'b0;
        else if (expire)             flag <= 1'b1;
        else if (wr_curr || rd_ctrl) flag <= 1'b0;
    end

    // interrupt request pulse
    always_ff @(posedge clk) begin
        if (!rst_n) irq_pulse <= 1'b0;
        else        irq_pulse <= expire & ie;
    end

    // read data multiplexer
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(OFF_CTRL)) begin
            rdata[BIT_EN]   = en;
            rdata[BIT_IE]   = ie;
            rdata[BIT_SRC]  = src_sel;
            rdata[BIT_FLAG] = flag;
        end else if (addr == ADDR_W'(OFF_RELD)) begin
            rdata = DATA_W'(reload);
        end else if (addr == ADDR_W'(OFF_CURR)) begin
            rdata = en ? DATA_W'(cnt) : '0;
        end else if (addr == ADDR_W'(OFF_CALIB)) begin
            rdata = DATA_W'(CALIB);
        end
    end

    // R4
    flag_on_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> flag);
    // R5
    irq_has_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> flag);
    // R7
    one_shot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && reload == '0) |=> !en);
    // R6
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ctrl && !expire) |=> !flag);
endmodule

// File: rtl/tick_timer_top.sv
// Top of the tick timer: joins the source select, down-counter and
// register file. Assumes tick enables are synchronous to clk.
module tick_timer_top #(
    parameter int          CNT_W  = 24,
    parameter int          ADDR_W = 8,
    parameter int          DATA_W = 32,
    parameter logic [31:0] CALIB  = 32'd10000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_tick_en,
    input  logic              ref_tick_en,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq_pulse
);
    logic             en, src_sel, tick, load, expire;
    logic [CNT_W-1:0] cnt, reload;

    tick_src_sel u_sel (
        .en(en), .src_sel(src_sel), .cpu_tick(cpu_tick_en),
        .ref_tick(ref_tick_en), .tick(tick)
    );

    tick_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load(load),
        .load_val(reload), .cnt(cnt), .expire(expire)
    );

    tick_ctrl_regs #(
        .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CALIB(CALIB)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .cnt(cnt), .expire(expire),
        .en(en), .src_sel(src_sel), .load(load), .reload(reload),
        .rdata(rdata), .irq_pulse(irq_pulse)
    );
endmodule

// File: tb/tick_timer_top_tb_top.sv
module tick_timer_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_tick_en = 1'b0, ref_tick_en = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = 32'h0;
    logic [31:0] rdata;
    logic        irq_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model state
    bit        m_en, m_ie, m_cs, m_flag, m_irq;
    bit [23:0] m_rel, m_cnt;

    always #5 clk = ~clk;

    tick_timer_top dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_tick_en(cpu_tick_en),
        .ref_tick_en(ref_tick_en), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_pulse(irq_pulse)
    );

    function automatic bit [31:0] m_read(input bit [7:0] a);
        case (a)
            8'h10: return {15'd0, m_flag, 13'd0, m_cs, m_ie, m_en};
            8'h14: return {8'd0, m_rel};
            8'h18: return m_en ? {8'd0, m_cnt} : 32'd0;
            8'h1C: return 32'd10000;
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(input string tag, input bit [31:0] act, input bit [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic m_reset();
        m_en = 0; m_ie = 0; m_cs = 0; m_flag = 0; m_irq = 0; m_rel = 0; m_cnt = 0;
    endtask

    // one bus cycle: drive, check read, advance model, check irq
    task automatic cyc(input bit wr, input bit rd, input bit [7:0] a,
                       input bit [31:0] d, input bit ct, input bit rt, input string tag);
        bit tick, wctrl, wcur, wrel, rctrl, load, expire;
        bit n_en, n_ie, n_cs, n_flag;
        bit [23:0] n_cnt;
        @(negedge clk);
        wr_en = wr; rd_en = rd; addr = a; wdata = d; cpu_tick_en = ct; ref_tick_en = rt;
        #1;
        if (rd) check(tag, rdata, m_read(a));
        tick  = m_en & (m_cs ? ct : rt);
        wctrl = wr && a == 8'h10;
        wrel  = wr && a == 8'h14;
        wcur  = wr && a == 8'h18;
        rctrl = rd && a == 8'h10;
        load  = wcur | (wctrl & !m_en & d[0] & (m_cnt == 0))
              | (wctrl & m_en & d[0] & (d[2] != m_cs));
        expire = tick & (m_cnt == 0) & !load;
        n_cnt = (load || expire) ? m_rel : (tick ? m_cnt - 24'd1 : m_cnt);
        n_en = wctrl ? d[0] : m_en;
        n_ie = wctrl ? d[1] : m_ie;
        n_cs = wctrl ? d[2] : m_cs;
        if (expire && m_rel == 0) n_en = 0;
        n_flag = expire ? 1'b1 : ((wcur || rctrl) ? 1'b0 : m_flag);
        @(posedge clk);
        #1;
        m_irq = expire & m_ie;
        m_cnt = n_cnt; m_en = n_en; m_ie = n_ie; m_cs = n_cs; m_flag = n_flag;
        if (wrel) m_rel = d[23:0];
        check({tag, " irq"}, {31'd0, irq_pulse}, {31'd0, m_irq});
    endtask

    task automatic wr(input bit [7:0] a, input bit [31:0] d, input string tag);
        cyc(1, 0, a, d, 0, 0, tag);
    endtask
    task automatic rd(input bit [7:0] a, input string tag);
        cyc(0, 1, a, 0, 0, 0, tag);
    endtask

    initial begin
        int gap, last;
        void'($urandom(32'd20240611));
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        rd(8'h10, "R1"); rd(8'h14, "R1"); rd(8'h18, "R1");
        check("R1 irq at reset", {31'd0, irq_pulse}, 32'd0);
        // R12 calibration, write ignored, unmapped
        wr(8'h1C, 32'h1234, "R12"); rd(8'h1C, "R12");
        check("R12 calib value", rdata, 32'd10000);
        rd(8'h20, "R12"); rd(8'h04, "R12");
        // R11 reload width
        wr(8'h14, 32'hFFFF_FFFF, "R11"); rd(8'h14, "R11");
        check("R11 reload upper zero", rdata, 32'h00FF_FFFF);
        // R2 write mask: enable off to keep state simple
        wr(8'h10, 32'hFFFF_FFFE, "R2"); rd(8'h10, "R2");
        check("R2 mask", rdata, 32'h0000_0006);
        wr(8'h10, 32'h0, "R2");

        // R3 reference source only, processor ticks ignored
        wr(8'h14, 32'd20, "R3"); wr(8'h18, 32'hDEAD, "R8");
        wr(8'h10, 32'h1, "R3");
        for (int i = 0; i < 6; i++) cyc(0, 1, 8'h18, 0, 1, i[0], "R3");
        rd(8'h18, "R3");
        check("R3 ref count", rdata, 32'd17);

        // R10 source change while enabled reloads
        wr(8'h10, 32'h5, "R10"); rd(8'h18, "R10");
        check("R10 reloaded", rdata, 32'd20);

        // R9 freeze / resume, zero read while disabled
        for (int i = 0; i < 3; i++) cyc(0, 0, 8'h0, 0, 1, 0, "R9");
        wr(8'h10, 32'h4, "R9");
        for (int i = 0; i < 3; i++) cyc(0, 1, 8'h18, 0, 1, 1, "R9");
        wr(8'h10, 32'h5, "R9"); rd(8'h18, "R9");
        check("R9 resumed", rdata, 32'd17);

        // R4/R5 period of reload+1 with interrupt
        wr(8'h14, 32'd3, "R4"); wr(8'h18, 0, "R8"); wr(8'h10, 32'h7, "R5");
        last = -1; gap = 0;
        for (int i = 0; i < 14; i++) begin
            cyc(0, 0, 8'h0, 0, 1, 0, "R4");
            if (irq_pulse) begin
                if (last >= 0) gap = i - last;
                last = i;
            end
        end
        check("R4 period", gap, 32'd4);
        // R5 interrupt disabled: expiries without pulses
        wr(8'h10, 32'h5, "R5");
        for (int i = 0; i < 10; i++) cyc(0, 0, 8'h0, 0, 1, 0, "R5");

        // R6 read every cycle with expiries colliding
        wr(8'h14, 32'd2, "R6"); wr(8'h18, 0, "R6");
        for (int i = 0; i < 9; i++) cyc(0, 1, 8'h10, 0, 1, 0, "R6");
        // R8 current write colliding with an expiring tick
        wr(8'h10, 32'h7, "R8"); wr(8'h14, 32'd1, "R8"); wr(8'h18, 0, "R8");
        cyc(0, 0, 8'h0, 0, 1, 0, "R8");
        cyc(1, 0, 8'h18, 32'h55, 1, 0, "R8");
        rd(8'h10, "R8"); rd(8'h18, "R8");

        // R7 one-shot
        wr(8'h14, 32'd0, "R7"); wr(8'h18, 0, "R7");
        for (int i = 0; i < 4; i++) cyc(0, 1, 8'h10, 0, 1, 1, "R7");
        check("R7 stopped", rdata & 32'h1, 32'h0);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            int op;
            bit [7:0] a;
            bit [31:0] d;
            op = $urandom_range(0, 9);
            a = 8'h10 + 8'($urandom_range(0, 4) * 4);
            d = $urandom;
            if (a == 8'h14) d = d & 32'h7;
            cyc(op == 0, op > 5, a, d, $urandom_range(0, 1) == 1,
                $urandom_range(0, 2) == 0, "R3 random");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule